// File: doc/BRIEF.md
# Two-Level Nested Interrupt Arbiter

This block sits between five interrupt sources and a small processor core. Two of the sources are active-low external pins. Each pin can latch on a falling edge or follow a low level. Two sources are timer overflow pulses, and one is a serial event pulse. The block holds a request flag for each source and gates the flags with a global enable and a per-source enable. It then picks one source to present to the core as a request with a vector index.

Each source carries one priority bit, and there are two levels. A high-level request may interrupt a low-level routine that is running. A request of equal or lower level waits until the running routine ends. A fixed polling order is used only to break ties between requests of the same level, and it never causes preemption. The core acknowledges a grant, which marks that grant's level as in service. The core ends a routine with a dedicated return pulse, which releases the highest level in service.

Top module: `irq_nest_arbiter`

## Requirements
- R1: After reset no request is presented, every flag is clear and no level is in service.
- R2: Sources carry vector indices 0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial. Among pending requests of one level, the lowest index is granted.
- R3: In `prio_hi_i`, bit i set to 1 puts source i at the high level. Any pending high-level request wins over every low-level request, whatever the indices.
- R4: While only the low level is in service, an enabled high-level request is presented.
- R5: While a level is in service, no request of that level or of a lower level is presented, even one with a lower index.
- R6: A source is granted only when `glb_en_i` and its bit of `src_en_i` are both 1. A disabled flag stays pending and is granted once it is enabled.
- R7: In edge mode (`ext_edge_i` bit = 1), a high-to-low pin transition sets the flag at the next clock edge. The flag stays set after the pin returns high and is cleared by acknowledge. A pin held low does not set the flag again.
- R8: In level mode (`ext_edge_i` bit = 0), the flag follows the inverted pin one clock later, and acknowledge does not clear it.
- R9: A timer overflow pulse sets its flag, and acknowledging that source clears it.
- R10: The serial flag is set by `ser_evt_i`. It is not cleared by acknowledge, only by `ser_clr_i`.
- R11: In-service state changes only on an accepted acknowledge or on `reti_i`. A return pulse releases the high level if it is in service, and otherwise the low level.
- R12: An acknowledge while `irq_req_o` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ext_pin_n_i | input | 2 | Active-low external request pins (bit 0 = external 0) |
| ext_edge_i | input | 2 | Per pin: 1 = falling-edge latch, 0 = low-level follow |
| tmr_ovf_i | input | 2 | Timer overflow pulses (bit 0 = timer 0) |
| ser_evt_i | input | 1 | Serial event pulse |
| ser_clr_i | input | 1 | Software clear of the serial flag |
| glb_en_i | input | 1 | Global interrupt enable |
| src_en_i | input | 5 | Per-source enable, indexed by vector |
| prio_hi_i | input | 5 | Per-source level, 1 = high, indexed by vector |
| irq_ack_i | input | 1 | Core acknowledges the presented request |
| reti_i | input | 1 | Return-from-interrupt pulse |
| irq_req_o | output | 1 | Request to the core |
| irq_vec_o | output | 3 | Vector index of the granted source |

## Verification
A wrong in-service bit shows on the very next cycle. A set bit that should be clear holds back a request that should appear. A clear bit that should be set lets a request through that should be blocked. A flag that is cleared wrongly or left set wrongly shows in the drain order of a set of pending sources, because each grant and return exposes the next pick one cycle later. A bad tie-break or level compare shows as a wrong vector on the first grant. The sweep therefore loads every pending set under every priority pattern and follows the whole drain sequence.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int NSRC = 5;
  localparam int NPAIR = 2;
  localparam int VW = $clog2(NSRC);
  localparam int NLVL = 2;
  localparam int SER_IDX = NSRC - 1;

  typedef logic [NSRC-1:0] src_vec_t;
  typedef logic [VW-1:0] vec_t;
  typedef logic [NLVL-1:0] lvl_vec_t;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_nest_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPAIR-1:0] ext_pin_n_i,
  input  logic [NPAIR-1:0] ext_edge_i,
  input  logic [NPAIR-1:0] tmr_ovf_i,
  input  logic             ser_evt_i,
  input  logic             ser_clr_i,
  input  src_vec_t         clr_i,
  output src_vec_t         flag_o
);
  logic [NPAIR-1:0] pin_q, pin_d;
  src_vec_t         flag_q, flag_d;

  // External pins sit on even indices, timers on odd ones.
  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    localparam int EI = 2 * g;
    localparam int TI = 2 * g + 1;
    assign flag_d[EI] = ext_edge_i[g]
                      ? ((pin_q[g] & ~ext_pin_n_i[g]) | (flag_q[EI] & ~clr_i[EI]))
                      : ~ext_pin_n_i[g];
    assign flag_d[TI] = tmr_ovf_i[g] | (flag_q[TI] & ~clr_i[TI]);
  end

  assign flag_d[SER_IDX] = ser_evt_i | (flag_q[SER_IDX] & ~ser_clr_i);
  assign pin_d = ext_pin_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= '1;
      flag_q <= '0;
    end else begin
      pin_q  <= pin_d;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  // R9
  tmr0_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i[1] && !tmr_ovf_i[0]) |=> !flag_o[1]);

  // R10
  ser_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o[SER_IDX] && !ser_clr_i) |=> flag_o[SER_IDX]);
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_nest_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t flag_i,
  input  logic     glb_en_i,
  input  src_vec_t src_en_i,
  input  src_vec_t prio_i,
  input  lvl_vec_t svc_i,
  output logic     req_o,
  output vec_t     vec_o,
  output logic     lvl_o
);
  src_vec_t elig, hi_c, lo_c;

  always_comb begin
    elig  = flag_i & src_en_i & {NSRC{glb_en_i}};
    hi_c  = elig & prio_i & {NSRC{~svc_i[1]}};
    lo_c  = elig & ~prio_i & {NSRC{~(|svc_i)}};
    req_o = 1'b0;
    vec_o = '0;
    lvl_o = 1'b0;
    if (|hi_c) begin
      req_o = 1'b1;
      lvl_o = 1'b1;
      for (int i = NSRC - 1; i >= 0; i--) begin
        if (hi_c[i]) vec_o = VW'(i);
      end
    end else if (|lo_c) begin
      req_o = 1'b1;
      for (int i = NSRC - 1; i >= 0; i--) begin
        if (lo_c[i]) vec_o = VW'(i);
      end
    end
  end

  // R6
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (glb_en_i && src_en_i[vec_o] && flag_i[vec_o]));

  // R5
  no_same_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (!svc_i[1] && (!svc_i[0] || prio_i[vec_o])));

  // R3
  lvl_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (lvl_o == prio_i[vec_o]));
endmodule

// File: rtl/irq_svc_tracker.sv
module irq_svc_tracker
  import irq_nest_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ack_fire_i,
  input  logic     lvl_i,
  input  logic     reti_i,
  output lvl_vec_t svc_o
);
  lvl_vec_t svc_q, svc_d;

  always_comb begin
    svc_d = svc_q;
    if (reti_i) begin
      if (svc_q[1]) svc_d[1] = 1'b0;
      else          svc_d[0] = 1'b0;
    end
    if (ack_fire_i) svc_d[lvl_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svc_q <= '0;
    else        svc_q <= svc_d;
  end

  assign svc_o = svc_q;

  // R11
  svc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_fire_i && !reti_i) |=> $stable(svc_q));

  // R11
  reti_hi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !ack_fire_i && svc_q[1]) |=> (!svc_q[1] && (svc_q[0] == $past(svc_q[0]))));
endmodule

// File: rtl/irq_nest_arbiter.sv
module irq_nest_arbiter
  import irq_nest_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPAIR-1:0] ext_pin_n_i,
  input  logic [NPAIR-1:0] ext_edge_i,
  input  logic [NPAIR-1:0] tmr_ovf_i,
  input  logic             ser_evt_i,
  input  logic             ser_clr_i,
  input  logic             glb_en_i,
  input  logic [NSRC-1:0]  src_en_i,
  input  logic [NSRC-1:0]  prio_hi_i,
  input  logic             irq_ack_i,
  input  logic             reti_i,
  output logic             irq_req_o,
  output logic [VW-1:0]    irq_vec_o
);
  logic [1:0] rs_q;
  logic       rst_int_n;
  src_vec_t   flags, clr_vec;
  lvl_vec_t   svc;
  logic       grant_lvl, ack_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  assign ack_fire = irq_ack_i & irq_req_o;
  assign clr_vec  = ack_fire ? (src_vec_t'(1) << irq_vec_o) : '0;

  irq_flag_bank u_flags (
    .clk(clk), .rst_n(rst_int_n),
    .ext_pin_n_i(ext_pin_n_i), .ext_edge_i(ext_edge_i),
    .tmr_ovf_i(tmr_ovf_i), .ser_evt_i(ser_evt_i), .ser_clr_i(ser_clr_i),
    .clr_i(clr_vec), .flag_o(flags)
  );

  irq_resolver u_pick (
    .clk(clk), .rst_n(rst_int_n),
    .flag_i(flags), .glb_en_i(glb_en_i), .src_en_i(src_en_i),
    .prio_i(prio_hi_i), .svc_i(svc),
    .req_o(irq_req_o), .vec_o(irq_vec_o), .lvl_o(grant_lvl)
  );

  irq_svc_tracker u_svc (
    .clk(clk), .rst_n(rst_int_n),
    .ack_fire_i(ack_fire), .lvl_i(grant_lvl), .reti_i(reti_i),
    .svc_o(svc)
  );

  // R12
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq_ack_i && !irq_req_o && !reti_i) |=> $stable(svc));
endmodule

// File: tb/test_irq_nest_arbiter.sv
module test_irq_nest_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pin_n = 2'b11, edge_m = 2'b11, ovf = 2'b00;
  logic       sevt = 1'b0, sclr = 1'b0, gen = 1'b1, ack = 1'b0, reti = 1'b0;
  logic [4:0] sen = 5'h1f, prio = 5'h00;
  logic       req;
  logic [2:0] vec;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  irq_nest_arbiter i_irq_nest_arbiter (
    .clk(clk), .rst_n(rst_n), .ext_pin_n_i(pin_n), .ext_edge_i(edge_m),
    .tmr_ovf_i(ovf), .ser_evt_i(sevt), .ser_clr_i(sclr), .glb_en_i(gen),
    .src_en_i(sen), .prio_hi_i(prio), .irq_ack_i(ack), .reti_i(reti),
    .irq_req_o(req), .irq_vec_o(vec)
  );

  task automatic chk(string r, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Request state as one number: 5 = nothing, else the vector.
  function automatic int got();
    return req ? int'(vec) : 5;
  endfunction

  function automatic int pick(logic [4:0] pend, logic [4:0] pr);
    for (int i = 0; i < 5; i++) if (pend[i] && pr[i]) return i;
    for (int i = 0; i < 5; i++) if (pend[i] && !pr[i]) return i;
    return 5;
  endfunction

  task automatic load(logic [4:0] m);
    pin_n = ~{m[2], m[0]};
    ovf   = {m[3], m[1]};
    sevt  = m[4];
    tick();
    pin_n = 2'b11; ovf = 2'b00; sevt = 1'b0;
    tick();
  endtask

  task automatic do_ack(logic clr_ser);
    ack = 1'b1; sclr = clr_ser;
    tick();
    ack = 1'b0; sclr = 1'b0;
  endtask

  task automatic do_reti();
    reti = 1'b1;
    tick();
    reti = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [4:0] pend;
    int e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R1 reset idle", got(), 5);

    // Sweep: every priority pattern against every pending set, drained in order.
    for (int p = 0; p < 32; p++) begin
      for (int m = 1; m < 32; m++) begin
        prio = 5'(p);
        load(5'(m));
        pend = 5'(m);
        while (pend != 0) begin
          e = pick(pend, prio);
          chk((p == 0) ? "R2 tie order" : "R3 level order", got(), e);
          do_ack(e == 4);
          pend[e] = 1'b0;
          do_reti();
        end
        chk("R9 R7 flags cleared after drain", got(), 5);
      end
    end

    // Nesting: timer 1 high, rest low.
    prio = 5'b01000;
    load(5'b10000);
    chk("R2 serial vector", got(), 4);
    do_ack(1'b1);
    chk("R5 low in service", got(), 5);
    load(5'b00001);
    chk("R5 earlier low blocked", got(), 5);
    repeat (4) tick();
    chk("R11 no release without reti", got(), 5);
    load(5'b01000);
    chk("R4 high preempts low", got(), 3);
    do_ack(1'b0);
    chk("R5 both levels busy", got(), 5);
    load(5'b01000);
    chk("R5 same high level blocked", got(), 5);
    do_reti();
    chk("R11 reti frees high first", got(), 3);
    do_ack(1'b0);
    do_reti();
    chk("R11 low still in service", got(), 5);
    do_reti();
    chk("R11 low released", got(), 0);
    do_ack(1'b0);
    do_reti();
    chk("R7 edge flag cleared", got(), 5);

    // Acknowledge with nothing presented.
    prio = 5'h00;
    do_ack(1'b0);
    load(5'b00010);
    chk("R12 idle ack ignored", got(), 1);
    do_ack(1'b0);
    do_reti();

    // Enables.
    gen = 1'b0;
    load(5'b00010);
    chk("R6 global off", got(), 5);
    gen = 1'b1;
    #1;
    chk("R6 global on", got(), 1);
    sen = 5'b11101;
    #1;
    chk("R6 source off", got(), 5);
    sen = 5'h1f;
    #1;
    chk("R6 pending kept", got(), 1);
    do_ack(1'b0);
    do_reti();

    // Edge mode on external 1.
    pin_n[1] = 1'b0;
    tick();
    chk("R7 edge sets", got(), 2);
    do_ack(1'b0);
    do_reti();
    chk("R7 held low no retrigger", got(), 5);
    pin_n[1] = 1'b1;
    tick();
    pin_n[1] = 1'b0;
    tick();
    pin_n[1] = 1'b1;
    tick();
    chk("R7 flag stays after pin high", got(), 2);
    do_ack(1'b0);
    do_reti();
    chk("R7 cleared by ack", got(), 5);

    // Level mode on external 1.
    edge_m[1] = 1'b0;
    pin_n[1] = 1'b0;
    tick();
    chk("R8 level request", got(), 2);
    do_ack(1'b0);
    do_reti();
    chk("R8 ack does not clear", got(), 2);
    pin_n[1] = 1'b1;
    tick();
    chk("R8 follows pin high", got(), 5);
    edge_m[1] = 1'b1;
    tick();

    // Serial flag under software control.
    load(5'b10000);
    do_ack(1'b0);
    do_reti();
    chk("R10 ack keeps serial", got(), 4);
    sclr = 1'b1;
    tick();
    sclr = 1'b0;
    chk("R10 software clear", got(), 5);

    // Timer cleared on ack.
    load(5'b01000);
    do_ack(1'b0);
    do_reti();
    chk("R9 timer cleared", got(), 5);

    summary();
    $finish;
  end
endmodule